// File: doc/BRIEF.md
# Synchronous Clock Source and Domain Prescaler

This block picks the main clock from one of three sources: the RC oscillator, the external crystal oscillator or the PLL. It then produces clock-enable strobes for four synchronous domains: the CPU, the high-speed bus (HSB) and two peripheral buses, PBA and PBB. Each independent domain either runs at the full main-clock rate or is divided by a power of two. The divided rate comes from a tap of one shared free-running binary prescaler. The HSB strobe always follows the CPU setting.

A write to the domain-setting port offers new settings for all three independent domains at once. A setting that would make the CPU slower than either peripheral bus is refused. An accepted setting is held as pending and takes effect at the next full wrap of the prescaler, so every tap restarts in phase and no shortened enable period appears. While a setting is pending, the ready flag is low and any further setting write is refused. An optional one-cycle interrupt pulse marks the cycle in which the new setting takes effect. A switch of the main source is taken only when the requested source reports ready.

Top module: `clkgen_sync_div`

## Requirements
- R1: Reset state: `main_src` is 0 (RC oscillator), all four enable strobes are high on every cycle, `ck_ready` is 1, and `ck_irq`, `cfg_busy_err`, `cfg_ratio_err` and `src_sel_err` are 0.
- R2: A `msel_wr` pulse with code `msel_d` selects the source given by that code: 0 is RC, 1 is the external oscillator, 2 is the PLL. Ready bit `src_rdy[code]` must be 1. `main_src` shows the new code from the cycle after the write.
- R3: A `msel_wr` with code 3, or with a code whose `src_rdy` bit is 0, leaves `main_src` unchanged and raises `src_sel_err` for exactly one cycle after the write.
- R4: The prescaler count is 0 after reset, advances by one each cycle and wraps at 2^PSC_W. A divided domain with select value n strobes only on cycles where the low n+1 count bits are all ones, which divides the clock by 2^(n+1). An undivided domain strobes on every cycle.
- R5: `en_hsb` equals `en_cpu` on every cycle.
- R6: An accepted `ck_wr` drops `ck_ready` from the next cycle. The pending settings of the CPU, PBA and PBB domains take effect together at the clock edge where the count is all ones. `ck_ready` is 1 again from that edge.
- R7: A domain written with its current divide-enable and select keeps an unbroken strobe pattern across the apply edge.
- R8: The ratio exponent is 0 when the domain is undivided and select+1 when it is divided. A `ck_wr` whose CPU exponent exceeds the PBA or PBB exponent is refused. The active and pending settings are kept, `ck_ready` stays 1, and `cfg_ratio_err` pulses for one cycle.
- R9: A `ck_wr` while `ck_ready` is 0 is ignored, so the pending setting is unchanged and applied later, and `cfg_busy_err` pulses for one cycle.
- R10: `ien_wr` loads the interrupt-enable bit from `ien_d` (reset 0). When that bit is set, `ck_irq` pulses for exactly the one cycle in which `ck_ready` returns to 1. When it is clear, `ck_irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock as selected |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_rdy | input | 3 | Source ready: bit 0 RC, bit 1 external oscillator, bit 2 PLL |
| msel_wr | input | 1 | Main-source select write strobe |
| msel_d | input | 2 | Requested source code |
| ck_wr | input | 1 | Domain-setting write strobe |
| cpu_div | input | 1 | CPU (and HSB) divide enable |
| cpu_sel | input | SEL_W | CPU prescaler tap |
| pba_div | input | 1 | PBA divide enable |
| pba_sel | input | SEL_W | PBA prescaler tap |
| pbb_div | input | 1 | PBB divide enable |
| pbb_sel | input | SEL_W | PBB prescaler tap |
| ien_wr | input | 1 | Interrupt-enable write strobe |
| ien_d | input | 1 | Interrupt-enable value |
| main_src | output | 2 | Active main-source code |
| ck_ready | output | 1 | Setting-ready flag |
| ck_irq | output | 1 | Setting-effective interrupt pulse |
| cfg_busy_err | output | 1 | Write-while-busy pulse |
| cfg_ratio_err | output | 1 | Ratio-violation pulse |
| src_sel_err | output | 1 | Refused source-switch pulse |
| en_cpu | output | 1 | CPU clock enable |
| en_hsb | output | 1 | HSB clock enable |
| en_pba | output | 1 | PBA clock enable |
| en_pbb | output | 1 | PBB clock enable |

## Verification
The bench builds the block with PSC_W = 4, which gives SEL_W = 2. The prescaler then wraps every 16 cycles. Pending settings therefore take effect within a short window, and a test of a few hundred cycles can exercise every tap up to the deepest divide-by-16. It can also write a setting during each pending window, test the refusal of a bad ratio at several exponent pairs, and show an unchanged domain staying in phase across the apply edge.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
   typedef enum logic [1:0] {
      SRC_RC   = 2'd0,
      SRC_XOSC = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_NONE = 2'd3
   } src_e;

   localparam int NUM_SRC = 3;
   // independent domains: 0 cpu (hsb follows), 1 pba, 2 pbb
   localparam int NUM_DOM = 3;
   localparam int DOM_CPU = 0;
   localparam int DOM_PBA = 1;
   localparam int DOM_PBB = 2;
endpackage

// File: rtl/cg_prescaler.sv
module cg_prescaler #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] taps,
   output logic         roll
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + W'(1);
   end

   // tap n is high once per 2^(n+1) cycles
   for (genvar n = 0; n < W; n++) begin : g_tap
      assign taps[n] = &cnt[n:0];
   end

   assign roll = taps[W-1];

   // R4
   wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      roll |=> (taps == '0));
   // R4
   tap0_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !taps[0] |=> taps[0]);
endmodule

// File: rtl/cg_dom_strobe.sv
module cg_dom_strobe #(
   parameter int W  = 8,
   parameter int SW = 3
) (
   input  logic          div,
   input  logic [SW-1:0] sel,
   input  logic [W-1:0]  taps,
   output logic          en
);
   assign en = div ? taps[sel] : 1'b1;
endmodule

// File: rtl/cg_main_sel.sv
module cg_main_sel
   import clkgen_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [1:0]         d,
   input  logic [NUM_SRC-1:0] src_rdy,
   output logic [1:0]         sel,
   output logic               err
);
   logic [3:0] rdy_ext;
   logic       tgt_ok;

   assign rdy_ext = {1'b0, src_rdy};
   assign tgt_ok  = rdy_ext[d];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel <= SRC_RC;
         err <= 1'b0;
      end else begin
         err <= 1'b0;
         if (wr) begin
            if (tgt_ok) sel <= d;
            else        err <= 1'b1;
         end
      end
   end

   // R3
   src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !rdy_ext[d]) |=> ($stable(sel) && err));
   // R2
   src_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && rdy_ext[d]) |=> (sel == $past(d) && !err));
endmodule

// File: rtl/cg_setting_ctrl.sv
module cg_setting_ctrl
   import clkgen_pkg::*;
#(
   parameter int SW = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr,
   input  logic [NUM_DOM-1:0]          div_in,
   input  logic [NUM_DOM-1:0][SW-1:0]  sel_in,
   input  logic                        roll,
   input  logic                        ien_wr,
   input  logic                        ien_d,
   output logic [NUM_DOM-1:0]          act_div,
   output logic [NUM_DOM-1:0][SW-1:0]  act_sel,
   output logic                        ready,
   output logic                        irq,
   output logic                        busy_err,
   output logic                        ratio_err
);
   logic [NUM_DOM-1:0]         pend_div;
   logic [NUM_DOM-1:0][SW-1:0] pend_sel;
   logic                       ien_q;
   logic                       ratio_ok;

   function automatic logic [SW:0] expo(input logic dv, input logic [SW-1:0] s);
      return dv ? ({1'b0, s} + (SW+1)'(1)) : '0;
   endfunction

   assign ratio_ok =
      (expo(div_in[DOM_CPU], sel_in[DOM_CPU]) <= expo(div_in[DOM_PBA], sel_in[DOM_PBA])) &&
      (expo(div_in[DOM_CPU], sel_in[DOM_CPU]) <= expo(div_in[DOM_PBB], sel_in[DOM_PBB]));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_div   <= '0;
         act_sel   <= '0;
         pend_div  <= '0;
         pend_sel  <= '0;
         ready     <= 1'b1;
         irq       <= 1'b0;
         busy_err  <= 1'b0;
         ratio_err <= 1'b0;
         ien_q     <= 1'b0;
      end else begin
         irq       <= 1'b0;
         busy_err  <= 1'b0;
         ratio_err <= 1'b0;
         if (!ready && roll) begin
            act_div <= pend_div;
            act_sel <= pend_sel;
            ready   <= 1'b1;
            irq     <= ien_q;
         end
         if (wr) begin
            if (!ready)         busy_err  <= 1'b1;
            else if (!ratio_ok) ratio_err <= 1'b1;
            else begin
               pend_div <= div_in;
               pend_sel <= sel_in;
               ready    <= 1'b0;
            end
         end
         if (ien_wr) ien_q <= ien_d;
      end
   end

   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !ready) |=> ($stable(pend_div) && $stable(pend_sel) && busy_err));
   // R8
   ratio_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ready && !ratio_ok) |=> (ready && ratio_err && $stable(act_div) && $stable(act_sel)));
   // R6
   apply_only_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!roll || ready) |=> ($stable(act_div) && $stable(act_sel)));
   // R6
   ready_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && roll) |=> ready);
   // R8
   act_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expo(act_div[DOM_CPU], act_sel[DOM_CPU]) <= expo(act_div[DOM_PBA], act_sel[DOM_PBA])) &&
      (expo(act_div[DOM_CPU], act_sel[DOM_CPU]) <= expo(act_div[DOM_PBB], act_sel[DOM_PBB])));
   // R10
   irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ready && !$past(ready)));
endmodule

// File: rtl/clkgen_sync_div.sv
module clkgen_sync_div
   import clkgen_pkg::*;
#(
   parameter  int PSC_W = 8,
   localparam int SEL_W = $clog2(PSC_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_rdy,
   input  logic               msel_wr,
   input  logic [1:0]         msel_d,
   input  logic               ck_wr,
   input  logic               cpu_div,
   input  logic [SEL_W-1:0]   cpu_sel,
   input  logic               pba_div,
   input  logic [SEL_W-1:0]   pba_sel,
   input  logic               pbb_div,
   input  logic [SEL_W-1:0]   pbb_sel,
   input  logic               ien_wr,
   input  logic               ien_d,
   output logic [1:0]         main_src,
   output logic               ck_ready,
   output logic               ck_irq,
   output logic               cfg_busy_err,
   output logic               cfg_ratio_err,
   output logic               src_sel_err,
   output logic               en_cpu,
   output logic               en_hsb,
   output logic               en_pba,
   output logic               en_pbb
);
   if (PSC_W < 2 || (1 << SEL_W) != PSC_W) begin : g_bad_width
      $error("PSC_W must be a power of two of at least 2");
   end

   logic [PSC_W-1:0]              taps;
   logic                          roll;
   logic [NUM_DOM-1:0]            div_in, act_div, en_vec;
   logic [NUM_DOM-1:0][SEL_W-1:0] sel_in, act_sel;

   assign div_in = {pbb_div, pba_div, cpu_div};
   assign sel_in = {pbb_sel, pba_sel, cpu_sel};

   cg_prescaler #(.W(PSC_W)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .taps (taps),
      .roll (roll)
   );

   cg_main_sel u_msel (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (msel_wr),
      .d      (msel_d),
      .src_rdy(src_rdy),
      .sel    (main_src),
      .err    (src_sel_err)
   );

   cg_setting_ctrl #(.SW(SEL_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (ck_wr),
      .div_in   (div_in),
      .sel_in   (sel_in),
      .roll     (roll),
      .ien_wr   (ien_wr),
      .ien_d    (ien_d),
      .act_div  (act_div),
      .act_sel  (act_sel),
      .ready    (ck_ready),
      .irq      (ck_irq),
      .busy_err (cfg_busy_err),
      .ratio_err(cfg_ratio_err)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      cg_dom_strobe #(.W(PSC_W), .SW(SEL_W)) u_stb (
         .div (act_div[d]),
         .sel (act_sel[d]),
         .taps(taps),
         .en  (en_vec[d])
      );
   end

   assign en_cpu = en_vec[DOM_CPU];
   assign en_hsb = en_vec[DOM_CPU];
   assign en_pba = en_vec[DOM_PBA];
   assign en_pbb = en_vec[DOM_PBB];
endmodule

// File: tb/clkgen_sync_div_test.sv
module clkgen_sync_div_test;
   localparam int PW = 4;
   localparam int SW = 2;
   localparam int WRAP = 1 << PW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] src_rdy = 3'b001;
   logic msel_wr = 0, ck_wr = 0, ien_wr = 0, ien_d = 0;
   logic [1:0] msel_d = 0;
   logic cpu_div = 0, pba_div = 0, pbb_div = 0;
   logic [SW-1:0] cpu_sel = 0, pba_sel = 0, pbb_sel = 0;
   logic [1:0] main_src;
   logic ck_ready, ck_irq, cfg_busy_err, cfg_ratio_err, src_sel_err;
   logic en_cpu, en_hsb, en_pba, en_pbb;

   always #10 clk = ~clk;

   clkgen_sync_div #(.PSC_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .src_rdy(src_rdy),
      .msel_wr(msel_wr), .msel_d(msel_d), .ck_wr(ck_wr),
      .cpu_div(cpu_div), .cpu_sel(cpu_sel), .pba_div(pba_div), .pba_sel(pba_sel),
      .pbb_div(pbb_div), .pbb_sel(pbb_sel), .ien_wr(ien_wr), .ien_d(ien_d),
      .main_src(main_src), .ck_ready(ck_ready), .ck_irq(ck_irq),
      .cfg_busy_err(cfg_busy_err), .cfg_ratio_err(cfg_ratio_err), .src_sel_err(src_sel_err),
      .en_cpu(en_cpu), .en_hsb(en_hsb), .en_pba(en_pba), .en_pbb(en_pbb)
   );

   typedef struct {
      string      tag;
      logic [10:0] exp;
   } item_t;
   item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;
   string phase = "R1 reset";

   // reference state, built from the requirements
   int cnt_m = 0;
   bit m_ready = 1, m_irq = 0, m_be = 0, m_re = 0, m_me = 0, m_ien = 0;
   bit [1:0] m_src = 0;
   bit a_div[3] = '{0, 0, 0};
   bit p_div[3] = '{0, 0, 0};
   bit [SW-1:0] a_sel[3] = '{0, 0, 0};
   bit [SW-1:0] p_sel[3] = '{0, 0, 0};

   function automatic int ex(bit dv, bit [SW-1:0] s);
      return dv ? int'(s) + 1 : 0;
   endfunction

   function automatic bit en_of(bit dv, bit [SW-1:0] s);
      int mask;
      if (!dv) return 1'b1;
      mask = (1 << (int'(s) + 1)) - 1;
      return (cnt_m & mask) == mask;
   endfunction

   function automatic logic [10:0] expected();
      bit c, a, b;
      c = en_of(a_div[0], a_sel[0]);
      a = en_of(a_div[1], a_sel[1]);
      b = en_of(a_div[2], a_sel[2]);
      return {c, c, a, b, m_ready, m_irq, m_be, m_re, m_me, m_src};
   endfunction

   // monitor: compare at the falling edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [10:0] act;
         it = sb_q.pop_front();
         act = {en_cpu, en_hsb, en_pba, en_pbb, ck_ready, ck_irq,
                cfg_busy_err, cfg_ratio_err, src_sel_err, main_src};
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b (cpu hsb pba pbb rdy irq busy ratio src msrc)",
                     it.tag, act, it.exp);
         end
      end
   end

   // one clock: advance the reference, release strobes, queue expectation
   task automatic cycle();
      bit roll, rdy0;
      @(posedge clk); #1;
      roll = (cnt_m == WRAP - 1);
      rdy0 = m_ready;
      m_irq = 0; m_be = 0; m_re = 0; m_me = 0;
      if (!rdy0 && roll) begin
         a_div = p_div; a_sel = p_sel; m_ready = 1; m_irq = m_ien;
      end
      if (ck_wr) begin
         if (!rdy0) m_be = 1;
         else if (ex(cpu_div, cpu_sel) > ex(pba_div, pba_sel) ||
                  ex(cpu_div, cpu_sel) > ex(pbb_div, pbb_sel)) m_re = 1;
         else begin
            p_div = '{cpu_div, pba_div, pbb_div};
            p_sel = '{cpu_sel, pba_sel, pbb_sel};
            m_ready = 0;
         end
      end
      if (ien_wr) m_ien = ien_d;
      if (msel_wr) begin
         if (msel_d < 2'd3 && src_rdy[msel_d]) m_src = msel_d;
         else m_me = 1;
      end
      cnt_m = (cnt_m + 1) % WRAP;
      ck_wr = 0; msel_wr = 0; ien_wr = 0;
      sb_q.push_back('{phase, expected()});
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic set_cfg(bit cd, bit [SW-1:0] cs, bit ad, bit [SW-1:0] as_,
                          bit bd, bit [SW-1:0] bs);
      cpu_div = cd; cpu_sel = cs; pba_div = ad; pba_sel = as_;
      pbb_div = bd; pbb_sel = bs; ck_wr = 1;
      cycle();
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 2 * WRAP && !m_ready; i++) cycle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      phase = "R1 reset state";
      sb_q.push_back('{phase, expected()});
      phase = "R1 R4 R5 undivided idle";
      run(20);

      phase = "R3 source not ready refused";
      msel_d = 2'd1; msel_wr = 1; cycle(); run(2);
      phase = "R3 code 3 refused";
      msel_d = 2'd3; msel_wr = 1; cycle(); run(2);
      src_rdy = 3'b111;
      phase = "R2 switch to PLL";
      msel_d = 2'd2; msel_wr = 1; cycle(); run(2);
      phase = "R2 switch to RC";
      msel_d = 2'd0; msel_wr = 1; cycle(); run(2);

      phase = "R10 enable irq";
      ien_d = 1; ien_wr = 1; cycle();
      phase = "R6 R4 R10 apply pba/2 pbb/4";
      set_cfg(0, 0, 1, 0, 1, 1);
      run(3);
      phase = "R9 write while busy";
      set_cfg(1, 1, 1, 3, 1, 3);
      wait_ready(); run(WRAP + 4);

      phase = "R8 cpu slower than pba refused";
      set_cfg(1, 2, 1, 0, 1, 3); run(4);
      phase = "R8 cpu slower than pbb refused";
      set_cfg(1, 1, 1, 3, 0, 0); run(WRAP);

      phase = "R7 pba pbb rewritten unchanged";
      set_cfg(1, 0, 1, 0, 1, 1);
      wait_ready(); run(WRAP + 2);

      phase = "R10 irq disabled";
      ien_d = 0; ien_wr = 1; cycle();
      phase = "R4 deepest tap all domains";
      set_cfg(1, 3, 1, 3, 1, 3);
      wait_ready(); run(2 * WRAP);

      phase = "R6 back to undivided";
      set_cfg(0, 0, 0, 0, 0, 0);
      wait_ready(); run(WRAP);

      @(negedge clk); #1;
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule